// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block sits between a clocked host and an 8K x 8 asynchronous static RAM. The host offers one single-beat request at a time: a read or a write of one byte at a 13-bit address. The controller answers by running a correctly timed asynchronous cycle on the memory pins. It drives the address, a pair of chip selects of opposite polarity (one active low, one active high), an active-low output enable and an active-low write enable. It controls the shared 8-bit data bus through separate outgoing data, incoming data and drive-enable signals.

Every phase of a cycle is counted out in clock cycles. Each count is the nanosecond minimum of the selected speed grade divided by the clock period and rounded up. One extra cycle of margin is added wherever output enable or the bus changes direction. Writes are controlled by write enable, and output enable stays inactive for the whole write. The controller only drives the bus after the memory has had time to release it. After reset the controller waits one full read-cycle time before it accepts the first request.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is high and afterwards until the first request can be taken, the memory is deselected: `mem_cs1_n`=1, `mem_cs2`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0. `ready` is 0 and rises after the ceil(tRC/CLK_NS)-th rising edge that follows the release of reset (9 at the fast grade with an 8 ns clock).
- R2: A request is taken at a rising edge where `req` and `ready` are both 1. `we_req`=1 selects a write and 0 selects a read. `ready` is 0 from the next cycle until the cycle and its recovery are complete. `req` is ignored while `ready` is 0. While `ready` is 1 the memory is deselected with both strobes high and the bus not driven.
- R3: A read asserts both selects and `mem_oe_n` together for N_RD = max(ceil(tAA), ceil(tOE), ceil(tRC)) + 1 cycles. `rdata` is loaded from `mem_dq_in` at the last of those cycles, so the byte stored at the address is returned. This is 10 cycles at the fast grade.
- R4: After the read strobe, selects and output enable drop. `ready` returns after ceil(tOHZ)+1 more cycles. A read keeps `ready` low for 15 edges at the fast grade and 20 at the slow grade.
- R5: During a write, `mem_oe_n` stays 1. `mem_we_n` is 0, with the device selected, for N_PULSE = max(ceil(tWP), ceil(tAW), ceil(tWHZ)+1+ceil(tDW)) cycles. This is 9 at the fast grade.
- R6: `mem_dq_oe` rises only after `mem_we_n` has been low for ceil(tWHZ)+1 cycles, and only while `mem_oe_n` is high. It falls at the edge where `mem_we_n` rises. `mem_dq_out` carries the write data.
- R7: After write enable rises, the selects drop and recovery lasts max(1, ceil(tWC) - N_PULSE) cycles. A write keeps `ready` low for 10 edges at the fast grade and 13 at the slow grade.
- R8: `mem_addr` does not change while the device is selected.
- R9: `GRADE`=0 uses the fast figures (cycle 70, access 70, OE access 35, OE release 30, WE pulse 45, address-to-end 60, data setup 30, WE release 30 ns). `GRADE`=1 uses the slow figures (100, 100, 50, 35, 60, 80, 40, 30 ns). `CLK_NS` gives the clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request strobe |
| we_req | input | 1 | 1 = write, 0 = read |
| addr | input | 13 | Host byte address |
| wdata | input | 8 | Host write data |
| ready | output | 1 | High when a request can be taken |
| rdata | output | 8 | Last byte read |
| mem_addr | output | 13 | Memory address |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data driven onto the bus |
| mem_dq_oe | output | 1 | Bus drive enable |
| mem_dq_in | input | 8 | Data received from the bus |

## Verification
At the fast grade with an 8 ns clock, `ready` comes back after the 15th rising edge that follows the edge taking a read, and after the 10th for a write. `rdata` is valid when `ready` comes back. The driver counts edges after acceptance and samples every output at falling edges, so each result is read half a cycle after the edge that produced it. The memory model stamps every pin change with the preceding rising edge. It hands back inverted data if a read is sampled before the access times have passed, and it measures pulse width, address-to-end, data setup and bus turn-around at each write-enable rise. A scoreboard queue holds the expected byte of every read and compares it as soon as `ready` rises again.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_REC,
    ST_WR_HIZ,
    ST_WR_DRV,
    ST_WR_REC
  } ctrl_state_t;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // nanosecond minimums per speed grade (0 fast, 1 slow)
  function automatic int t_cycle(input int g);  return (g == 0) ? 70 : 100; endfunction
  function automatic int t_acc(input int g);    return (g == 0) ? 70 : 100; endfunction
  function automatic int t_oeacc(input int g);  return (g == 0) ? 35 : 50;  endfunction
  function automatic int t_oerel(input int g);  return (g == 0) ? 30 : 35;  endfunction
  function automatic int t_wpulse(input int g); return (g == 0) ? 45 : 60;  endfunction
  function automatic int t_aend(input int g);   return (g == 0) ? 60 : 80;  endfunction
  function automatic int t_dset(input int g);   return (g == 0) ? 30 : 40;  endfunction
  function automatic int t_werel(input int g);  return 30; endfunction

  // phase lengths in clock cycles
  function automatic int len_init(input int g, input int c);
    return ns_to_cyc(t_cycle(g), c);
  endfunction
  function automatic int len_rd(input int g, input int c);
    return imax(imax(ns_to_cyc(t_acc(g), c), ns_to_cyc(t_oeacc(g), c)),
                ns_to_cyc(t_cycle(g), c)) + 1;
  endfunction
  function automatic int len_rdrec(input int g, input int c);
    return ns_to_cyc(t_oerel(g), c) + 1;
  endfunction
  function automatic int len_whz(input int g, input int c);
    return ns_to_cyc(t_werel(g), c) + 1;
  endfunction
  function automatic int len_pulse(input int g, input int c);
    return imax(imax(ns_to_cyc(t_wpulse(g), c), ns_to_cyc(t_aend(g), c)),
                len_whz(g, c) + ns_to_cyc(t_dset(g), c));
  endfunction
  function automatic int len_wrec(input int g, input int c);
    return imax(1, ns_to_cyc(t_cycle(g), c) - len_pulse(g, c));
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W    = 4,
  parameter int RST_LOAD = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= CNT_W'(RST_LOAD);
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int N_RD    = 10,
  parameter int N_RDREC = 5,
  parameter int N_WHZ   = 5,
  parameter int N_WDRV  = 4,
  parameter int N_WREC  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             we_req,
  input  logic             expired,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept,
  output logic             capture,
  output logic             ready,
  output logic             cs1_n,
  output logic             cs2,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe
);

  ctrl_state_t state, nxt;
  logic        sel_nxt;

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (state)
      ST_INIT:   if (expired) nxt = ST_IDLE;
      ST_IDLE:   if (req) begin
                   accept = 1'b1;
                   load   = 1'b1;
                   if (we_req) begin
                     nxt      = ST_WR_HIZ;
                     load_val = CNT_W'(N_WHZ - 1);
                   end else begin
                     nxt      = ST_RD_ACC;
                     load_val = CNT_W'(N_RD - 1);
                   end
                 end
      ST_RD_ACC: if (expired) begin
                   capture  = 1'b1;
                   nxt      = ST_RD_REC;
                   load     = 1'b1;
                   load_val = CNT_W'(N_RDREC - 1);
                 end
      ST_RD_REC: if (expired) nxt = ST_IDLE;
      ST_WR_HIZ: if (expired) begin
                   nxt      = ST_WR_DRV;
                   load     = 1'b1;
                   load_val = CNT_W'(N_WDRV - 1);
                 end
      ST_WR_DRV: if (expired) begin
                   nxt      = ST_WR_REC;
                   load     = 1'b1;
                   load_val = CNT_W'(N_WREC - 1);
                 end
      ST_WR_REC: if (expired) nxt = ST_IDLE;
      default:   nxt = ST_INIT;
    endcase
  end

  assign sel_nxt = (nxt == ST_RD_ACC) || (nxt == ST_WR_HIZ) || (nxt == ST_WR_DRV);

  // strobes are registered from the next state so the pins never glitch
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_INIT;
      ready <= 1'b0;
      cs1_n <= 1'b1;
      cs2   <= 1'b0;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      state <= nxt;
      ready <= (nxt == ST_IDLE);
      cs1_n <= ~sel_nxt;
      cs2   <= sel_nxt;
      oe_n  <= (nxt != ST_RD_ACC);
      we_n  <= !((nxt == ST_WR_HIZ) || (nxt == ST_WR_DRV));
      dq_oe <= (nxt == ST_WR_DRV);
    end
  end

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int GRADE  = 0,
  parameter int CLK_NS = 8,
  parameter int AW     = 13,
  parameter int DW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          we_req,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs1_n,
  output logic          mem_cs2,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int N_INIT  = len_init(GRADE, CLK_NS);
  localparam int N_RD    = len_rd(GRADE, CLK_NS);
  localparam int N_RDREC = len_rdrec(GRADE, CLK_NS);
  localparam int N_WHZ   = len_whz(GRADE, CLK_NS);
  localparam int N_PULSE = len_pulse(GRADE, CLK_NS);
  localparam int N_WDRV  = N_PULSE - N_WHZ;
  localparam int N_WREC  = len_wrec(GRADE, CLK_NS);
  localparam int N_MAX   = imax(imax(imax(N_INIT, N_RD), imax(N_RDREC, N_WHZ)),
                                imax(N_WDRV, N_WREC));
  localparam int CNT_W   = $clog2(N_MAX + 1);

  logic             load, expired, accept, capture;
  logic [CNT_W-1:0] load_val;

  sram_phase_timer #(
    .CNT_W    (CNT_W),
    .RST_LOAD (N_INIT - 1)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  sram_ctrl_fsm #(
    .CNT_W   (CNT_W),
    .N_RD    (N_RD),
    .N_RDREC (N_RDREC),
    .N_WHZ   (N_WHZ),
    .N_WDRV  (N_WDRV),
    .N_WREC  (N_WREC)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .we_req   (we_req),
    .expired  (expired),
    .load     (load),
    .load_val (load_val),
    .accept   (accept),
    .capture  (capture),
    .ready    (ready),
    .cs1_n    (mem_cs1_n),
    .cs2      (mem_cs2),
    .oe_n     (mem_oe_n),
    .we_n     (mem_we_n),
    .dq_oe    (mem_dq_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rdata      <= '0;
    end else begin
      if (accept) begin
        mem_addr   <= addr;
        mem_dq_out <= wdata;
      end
      if (capture) rdata <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int GRADE  = 0,
  parameter int CLK_NS = 8,
  parameter int AW     = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          ready,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs1_n,
  input logic          mem_cs2,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe
);

  localparam int C_WHZ   = len_whz(GRADE, CLK_NS);
  localparam int C_PULSE = len_pulse(GRADE, CLK_NS);

  logic       sel;
  logic [7:0] we_low_cnt;

  assign sel = !mem_cs1_n && mem_cs2;

  always_ff @(posedge clk) begin
    if (rst)                      we_low_cnt <= '0;
    else if (mem_we_n)            we_low_cnt <= '0;
    else if (we_low_cnt != 8'hFF) we_low_cnt <= we_low_cnt + 8'd1;
  end

  AST_SEL_PAIR: assert property (@(posedge clk) disable iff (rst)
    mem_cs1_n == !mem_cs2) else $error("selects out of step"); // R3
  AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n || !mem_oe_n) |-> sel) else $error("strobe without select"); // R5
  AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n) else $error("oe low in write"); // R5
  AST_DRIVE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n)) else $error("bus driven outside write"); // R6
  AST_DRIVE_AFTER_HIZ: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (we_low_cnt == 8'(C_WHZ))) else $error("drive too early"); // R6
  AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_low_cnt == 8'(C_PULSE))) else $error("we pulse length"); // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (sel && $past(sel)) |-> $stable(mem_addr)) else $error("address moved"); // R8
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
    ready |-> (!sel && mem_we_n && mem_oe_n && !mem_dq_oe)) else $error("busy pins while ready"); // R2

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
  .GRADE  (GRADE),
  .CLK_NS (CLK_NS),
  .AW     (AW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ready     (ready),
  .mem_addr  (mem_addr),
  .mem_cs1_n (mem_cs1_n),
  .mem_cs2   (mem_cs2),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_cycle_ctrl_bench.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_bench;

  localparam int GRADE  = 0;
  localparam int CLK_NS = 8;
  localparam int HALF   = CLK_NS / 2;

  // grade figures in ns (R9)
  localparam int T_CYC = GRADE ? 100 : 70;
  localparam int T_AA  = GRADE ? 100 : 70;
  localparam int T_OEA = GRADE ? 50  : 35;
  localparam int T_OER = GRADE ? 35  : 30;
  localparam int T_WP  = GRADE ? 60  : 45;
  localparam int T_AW  = GRADE ? 80  : 60;
  localparam int T_DS  = GRADE ? 40  : 30;
  localparam int T_WER = 30;

  function automatic int up(input int ns); return (ns + CLK_NS - 1) / CLK_NS; endfunction
  function automatic int mx(input int a, input int b); return a > b ? a : b; endfunction

  localparam int EXP_INIT  = up(T_CYC);
  localparam int EXP_PULSE = mx(mx(up(T_WP), up(T_AW)), up(T_WER) + 1 + up(T_DS));
  localparam int EXP_RD    = mx(mx(up(T_AA), up(T_OEA)), up(T_CYC)) + 1 + up(T_OER) + 1;
  localparam int EXP_WR    = EXP_PULSE + mx(1, up(T_CYC) - EXP_PULSE);

  logic        clk = 1'b0;
  logic        rst, req, we_req;
  logic [12:0] addr;
  logic [7:0]  wdata;
  logic        ready;
  logic [7:0]  rdata;
  logic [12:0] mem_addr;
  logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  always #(HALF) clk = ~clk;

  sram_cycle_ctrl #(.GRADE(GRADE), .CLK_NS(CLK_NS)) u_sram_cycle_ctrl (
    .clk(clk), .rst(rst), .req(req), .we_req(we_req), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n),
    .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural memory with timing checks ----------------
  logic [7:0]  marr   [0:8191];
  logic [7:0]  shadow [0:8191];
  longint t_sel, t_addr, t_oe_fall, t_oe_rise, t_we_fall, t_dq_on, t_start;
  bit     started;
  logic        p_sel, p_oe_n, p_we_n, p_dq_oe;
  logic [12:0] p_addr;
  logic [7:0]  p_dq;

  initial begin
    for (int i = 0; i < 8192; i++) begin marr[i] = 8'h00; shadow[i] = 8'h00; end
    t_sel = 0; t_addr = 0; t_oe_fall = 0; t_oe_rise = 0; t_we_fall = 0;
    t_dq_on = 0; t_start = 0; started = 1'b0; mem_dq_in = 8'h00;
    p_sel = 1'b0; p_oe_n = 1'b1; p_we_n = 1'b1; p_dq_oe = 1'b0; p_addr = '0; p_dq = '0;
  end

  always @(negedge clk) begin
    longint now, tn;
    logic   sel;
    tn  = longint'($time);
    now = tn - HALF;           // pins change at the preceding rising edge
    sel = !mem_cs1_n && mem_cs2;
    if (!rst) begin
      if (sel && !p_sel) begin
        if (started) chk(now - t_start >= T_CYC, "R3 R7 cycle spacing", int'(now - t_start), T_CYC);
        t_start = now; started = 1'b1; t_sel = now;
      end
      if (mem_addr != p_addr) begin
        if (sel && p_sel) chk(1'b0, "R8 address moved while selected", mem_addr, p_addr);
        t_addr = now;
      end
      if (!mem_oe_n && p_oe_n) t_oe_fall = now;
      if (mem_oe_n && !p_oe_n) t_oe_rise = now;
      if (!mem_we_n && p_we_n) t_we_fall = now;
      if (mem_dq_oe && !p_dq_oe) begin
        t_dq_on = now;
        chk(mem_oe_n && !mem_we_n && (now - t_we_fall >= T_WER) && (now - t_oe_rise >= T_OER),
            "R6 bus turn-around", int'(now - t_we_fall), T_WER);
      end
      if (mem_we_n && !p_we_n) begin
        chk(now - t_we_fall >= T_WP, "R5 write pulse width", int'(now - t_we_fall), T_WP);
        chk(now - (t_addr > t_sel ? t_addr : t_sel) >= T_AW, "R5 address to end of write",
            int'(now - t_sel), T_AW);
        chk(p_dq_oe && !mem_dq_oe && (now - t_dq_on >= T_DS), "R6 data setup and release",
            int'(now - t_dq_on), T_DS);
        chk(p_sel, "R5 selected at end of write", p_sel, 1);
        marr[p_addr] = p_dq;
      end
      if (sel && !mem_oe_n && mem_we_n) begin
        if ((tn - t_sel >= T_AA) && (tn - t_addr >= T_AA) && (tn - t_oe_fall >= T_OEA))
          mem_dq_in = marr[mem_addr];
        else
          mem_dq_in = ~marr[mem_addr];
      end else begin
        mem_dq_in = 8'h00;
      end
    end else begin
      started = 1'b0;
      mem_dq_in = 8'h00;
    end
    p_sel = sel; p_oe_n = mem_oe_n; p_we_n = mem_we_n; p_dq_oe = mem_dq_oe;
    p_addr = mem_addr; p_dq = mem_dq_out;
  end

  // ---------------- scoreboard monitor ----------------
  logic [7:0] exp_q [$];
  logic       rdy_q = 1'b0;

  always @(negedge clk) begin
    logic [7:0] e;
    if (ready && !rdy_q && exp_q.size() != 0) begin
      e = exp_q.pop_front();
      chk(rdata == e, "R3 read data", rdata, e);
    end
    rdy_q = ready;
  end

  // ---------------- driver ----------------
  task automatic run_op(input bit w, input logic [12:0] a, input logic [7:0] d,
                        input bit poke, input logic [12:0] pa, input logic [7:0] pd,
                        output int busy);
    @(negedge clk);
    req = 1'b1; we_req = w; addr = a; wdata = d;
    if (w) shadow[a] = d;
    else   exp_q.push_back(shadow[a]);
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    busy = 0;
    while (1) begin
      @(posedge clk);
      busy++;
      @(negedge clk);
      if (poke && busy == 2) begin req = 1'b1; we_req = 1'b1; addr = pa; wdata = pd; end
      if (poke && busy == 3) begin req = 1'b0; addr = a; end
      if (ready || busy > 200) break;
    end
    req = 1'b0;
  endtask

  task automatic do_write(input logic [12:0] a, input logic [7:0] d);
    int b;
    run_op(1'b1, a, d, 1'b0, '0, '0, b);
    chk(b == EXP_WR, "R7 R9 write busy edges", b, EXP_WR);
  endtask

  task automatic do_read(input logic [12:0] a);
    int b;
    run_op(1'b0, a, 8'h00, 1'b0, '0, '0, b);
    chk(b == EXP_RD, "R4 R9 read busy edges", b, EXP_RD);
  endtask

  function automatic logic [7:0] pat(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  initial begin
    int k;
    rst = 1'b1; req = 1'b0; we_req = 1'b0; addr = '0; wdata = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(ready == 1'b0, "R1 ready low in reset", ready, 0);
    chk(mem_cs1_n == 1'b1 && mem_cs2 == 1'b0, "R1 deselected in reset", {mem_cs1_n, mem_cs2}, 2);
    chk(mem_oe_n && mem_we_n && !mem_dq_oe, "R1 strobes idle in reset",
        {mem_oe_n, mem_we_n, mem_dq_oe}, 6);
    rst = 1'b0;
    k = 0;
    while (1) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (k < EXP_INIT) chk(!ready && mem_cs1_n && !mem_cs2, "R1 quiet before first access", ready, 0);
      if (ready || k > 200) break;
    end
    chk(k == EXP_INIT, "R1 start-up wait edges", k, EXP_INIT);
    repeat (3) @(negedge clk);
    chk(ready && mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && !mem_dq_oe,
        "R2 idle pins while ready", ready, 1);

    // corner values at both address ends, write then immediate read
    do_write(13'd0, 8'hFF);    do_read(13'd0);
    do_write(13'h1FFF, 8'h00); do_read(13'h1FFF);
    do_write(13'h1FFF, 8'hA5); do_read(13'h1FFF);

    // R2: request raised while busy must be ignored
    begin
      int b;
      do_write(13'd100, 8'h3C);
      do_write(13'd200, 8'hC3);
      run_op(1'b0, 13'd100, 8'h00, 1'b1, 13'd200, 8'h99, b);
      chk(b == EXP_RD, "R2 busy length with stray request", b, EXP_RD);
      do_read(13'd200);
      chk(rdata == 8'hC3, "R2 stray request ignored", rdata, 8'hC3);
    end

    // sweep: pattern across the address space, then read back
    for (int a = 0; a < 8192; a += 7) do_write(13'(a), pat(13'(a)));
    do_write(13'h1FFF, pat(13'h1FFF));
    for (int a = 0; a < 8192; a += 7) do_read(13'(a));
    do_read(13'h1FFF);

    // back-to-back reads of the same and neighbouring addresses
    do_read(13'd7); do_read(13'd7); do_read(13'd14);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all reads answered", exp_q.size(), 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 run did not complete actual=%0d expected=%0d", 200000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule